// File: doc/BRIEF.md
# ATA PIO Cycle Timing Generator

This block runs host-side programmed-I/O register cycles on a 16-bit parallel drive bus. A requester hands it one access at a time: the target drive (0 or 1), which chip-select block and register address, the direction, and the write data. The block places the address and chip-select on the bus, waits out an address setup interval, pulses the read or write strobe low, holds the bus, and then pads the cycle until both the minimum cycle time and the strobe recovery time have passed. It returns read data together with a one-cycle completion pulse.

All intervals are counts of the system clock held in two packed 32-bit timing words per drive. Software programs them through a small write port. The block keeps a working copy of one drive's set. When a request targets a drive whose set is not the loaded one, it spends one extra cycle loading that set before the bus cycle starts. When the ready handshake is enabled, the drive can stretch the strobe by holding its ready line low. Either of two soft-reset configuration bits forces the engine idle for as long as it is set.

Top module: `pio_xfer_eng`

## Requirements
- R1: Timing word A (tm_word=0) packs the minimum cycle count in bits 31:24, the 8-bit-access strobe count in 23:16, the 16-bit-access strobe count in 15:8 and the recovery count in 7:0. Timing word B (tm_word=1) packs the write hold count in 31:24, the address setup count in 23:16 and the ready setup count in 15:8, with 7:0 unused. A write with tm_we high stores tm_wdata into the chosen word of drive tm_drive.
- R2: After reset, both drives hold PIO mode 0 counts. Each count is ceil(ns*1000/CLK_PS) for 600 ns cycle, 70 ns setup, 290 ns 8-bit strobe, 165 ns 16-bit strobe, 0 ns recovery, 30 ns hold and 35 ns ready setup. The bus is idle at reset: ata_cs_n=2'b11, both strobes high, ata_dd_oe low, busy low and done low.
- R3: A cycle asserts chip-select and address for max(setup,1) cycles with both strobes high. It then holds one strobe low for max(width,1) cycles and keeps chip-select asserted for the hold count after the strobe rises. The width is the 16-bit field when req_cs=0 and req_reg=0, and the 8-bit field otherwise. req_cs=0 drives ata_cs_n=2'b10 and req_cs=1 drives 2'b01, and ata_da carries req_reg.
- R4: Counted from the first chip-select cycle, the active part of a cycle lasts max(cycle, S+max(recovery,1)) clocks, where S is setup + strobe + hold as driven. Chip-select is deasserted during the padding.
- R5: If no set is loaded, or the loaded set belongs to the other drive, one load cycle with busy high and chip-select deasserted comes before the setup phase. Otherwise setup starts in the cycle after acceptance. Reset, either soft-reset bit, or a timing write to the loaded drive clears the loaded set.
- R6: With cfg_rdy_en high, the strobe does not end while the synchronised ready input is low, once the ready setup count of strobe cycles has passed. The strobe ends RDY_SYNC cycles after ready returns high, provided the width has been met.
- R7: With cfg_rdy_en low, the ready input has no effect on strobe width.
- R8: While cfg_sm_rst or cfg_fifo_rst is high, a cycle in progress is abandoned in the next clock: busy goes low, both strobes go high and chip-select is deasserted. req_ready stays low, requests are not accepted, and done is not raised.
- R9: busy is high from the cycle after acceptance until the cycle ends. req_ready is high only while idle and not held in soft reset.
- R10: done is a one-cycle pulse in the first idle cycle after a cycle ends. rd_data then holds the bus value sampled as the read strobe rose: all 16 bits for a 16-bit access, and the low byte with the upper byte zero for an 8-bit access.
- R11: A read drives ata_dior_n low and never drives ata_dd_oe. A write drives ata_diow_n low, with ata_dd_oe high and ata_dd_out equal to req_wdata through setup, strobe and hold. The two strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sm_rst | input | 1 | Engine soft reset, holds idle while high |
| cfg_fifo_rst | input | 1 | Buffer soft reset, also holds the engine idle |
| cfg_rdy_en | input | 1 | Enables strobe stretching by the ready line |
| tm_we | input | 1 | Timing word write strobe |
| tm_drive | input | 1 | Drive whose timing set is written |
| tm_word | input | 1 | 0 selects word A, 1 selects word B |
| tm_wdata | input | 32 | Timing word value |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_drive | input | 1 | Target drive |
| req_cs | input | 1 | 0 command block, 1 control block |
| req_reg | input | 3 | Register address within the block |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 16 | Write data |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read data, valid with done |
| busy | output | 1 | Transaction in progress |
| ata_cs_n | output | 2 | Active-low chip-selects |
| ata_da | output | 3 | Register address lines |
| ata_dior_n | output | 1 | Active-low read strobe |
| ata_diow_n | output | 1 | Active-low write strobe |
| ata_dd_out | output | 16 | Data bus output value |
| ata_dd_oe | output | 1 | Data bus output enable |
| ata_dd_in | input | 16 | Data bus input value |
| ata_iordy | input | 1 | Drive ready line |

## Verification
Every PIO mode from 0 to 4 is programmed into both drives in mirrored order, and each drive is driven with 16-bit reads and writes and 8-bit reads and writes. This separates the two strobe-width fields, shows whether each field sits at its bit position, and shows whether recovery or the cycle time sets the cycle length. Alternating drives against repeated targets of the same drive tells a needed set load from an unneeded one. Holding ready low while stretching is enabled and then disabled separates the handshake from a plain width. Asserting each soft-reset bit in the middle of a strobe shows abandonment, shows that requests are refused, and shows that a reload follows.

// File: rtl/pio_tm_pkg.sv
`timescale 1ns/1ps
package pio_tm_pkg;

   localparam int N_DRIVES = 2;
   localparam int FLD_W    = 8;

   // field selectors for the nanosecond table
   localparam int F_CYC  = 0;
   localparam int F_ASU  = 1;
   localparam int F_W8   = 2;
   localparam int F_W16  = 3;
   localparam int F_REC  = 4;
   localparam int F_HOLD = 5;
   localparam int F_RDY  = 6;

   typedef enum logic [2:0] {
      ST_IDLE, ST_LOAD, ST_SETUP, ST_STRB, ST_HOLD, ST_RECOV
   } seq_st_e;

   typedef struct packed {
      logic [FLD_W-1:0] cyc;
      logic [FLD_W-1:0] w8;
      logic [FLD_W-1:0] w16;
      logic [FLD_W-1:0] rec;
      logic [FLD_W-1:0] hold;
      logic [FLD_W-1:0] asu;
      logic [FLD_W-1:0] rdy;
   } tm_set_t;

   function automatic tm_set_t tm_unpack(logic [31:0] wa, logic [31:0] wb);
      tm_set_t s;
      s.cyc  = wa[31:24];
      s.w8   = wa[23:16];
      s.w16  = wa[15:8];
      s.rec  = wa[7:0];
      s.hold = wb[31:24];
      s.asu  = wb[23:16];
      s.rdy  = wb[15:8];
      return s;
   endfunction

   function automatic int pio_ns(int fld, int mode);
      int r;
      r = 0;
      case (fld)
         F_CYC:  case (mode) 0: r = 600; 1: r = 383; 2: r = 240; 3: r = 180; default: r = 120; endcase
         F_ASU:  case (mode) 0: r = 70;  1: r = 50;  2: r = 30;  3: r = 30;  default: r = 25;  endcase
         F_W8:   case (mode) 0: r = 290; 1: r = 290; 2: r = 290; 3: r = 80;  default: r = 70;  endcase
         F_W16:  case (mode) 0: r = 165; 1: r = 125; 2: r = 100; 3: r = 80;  default: r = 70;  endcase
         F_REC:  case (mode) 3: r = 70;  4: r = 25;  default: r = 0; endcase
         F_HOLD: case (mode) 0: r = 30;  1: r = 20;  2: r = 15;  default: r = 10; endcase
         default: r = 35;
      endcase
      return r;
   endfunction

   function automatic int clk_cnt(int ns, int ps);
      return (ns * 1000 + ps - 1) / ps;
   endfunction

   function automatic logic [31:0] word_a(int mode, int ps);
      return {8'(clk_cnt(pio_ns(F_CYC, mode), ps)), 8'(clk_cnt(pio_ns(F_W8, mode), ps)),
              8'(clk_cnt(pio_ns(F_W16, mode), ps)), 8'(clk_cnt(pio_ns(F_REC, mode), ps))};
   endfunction

   function automatic logic [31:0] word_b(int mode, int ps);
      return {8'(clk_cnt(pio_ns(F_HOLD, mode), ps)), 8'(clk_cnt(pio_ns(F_ASU, mode), ps)),
              8'(clk_cnt(pio_ns(F_RDY, mode), ps)), 8'h00};
   endfunction

endpackage

// File: rtl/pio_tm_bank.sv
`timescale 1ns/1ps
module pio_tm_bank
   import pio_tm_pkg::*;
#(
   parameter int CLK_PS = 5000,
   localparam int DRV_W = $clog2(N_DRIVES)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [DRV_W-1:0] wr_drv,
   input  logic             wr_word,
   input  logic [31:0]      wr_data,
   input  logic [DRV_W-1:0] rd_drv,
   output tm_set_t          rd_set
);

   localparam logic [31:0] DEF_A = word_a(0, CLK_PS);
   localparam logic [31:0] DEF_B = word_b(0, CLK_PS);

   logic [31:0] wa [N_DRIVES];
   logic [31:0] wb [N_DRIVES];

   for (genvar d = 0; d < N_DRIVES; d++) begin : g_drv
      logic [31:0] a_q, b_q;
      logic        hit;
      assign hit = we && (wr_drv == DRV_W'(d));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            a_q <= DEF_A;
            b_q <= DEF_B;
         end else if (hit) begin
            if (wr_word) b_q <= wr_data;
            else         a_q <= wr_data;
         end
      end
      assign wa[d] = a_q;
      assign wb[d] = b_q;
   end

   assign rd_set = tm_unpack(wa[rd_drv], wb[rd_drv]);

endmodule

// File: rtl/pio_rdy_sync.sv
`timescale 1ns/1ps
module pio_rdy_sync #(
   parameter int STAGES = 2
)(
   input  logic clk,
   input  logic rst_n,
   input  logic rdy_in,
   output logic rdy_out
);

   if (STAGES == 0) begin : g_raw
      assign rdy_out = rdy_in;
   end else if (STAGES == 1) begin : g_one
      logic s_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) s_q <= 1'b1;
         else        s_q <= rdy_in;
      end
      assign rdy_out = s_q;
   end else begin : g_chain
      logic [STAGES-1:0] s_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) s_q <= '1;
         else        s_q <= {s_q[STAGES-2:0], rdy_in};
      end
      assign rdy_out = s_q[STAGES-1];
   end

endmodule

// File: rtl/pio_cycle_seq.sv
`timescale 1ns/1ps
module pio_cycle_seq
   import pio_tm_pkg::*;
#(
   parameter int EL_W = 10
)(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    soft_rst,
   input  logic    start,
   input  logic    need_load,
   input  logic    is16,
   input  logic    rdy_en,
   input  logic    rdy,
   input  tm_set_t tm,
   output seq_st_e st,
   output logic    load_en,
   output logic    strb_end,
   output logic    fin
);

   localparam logic [EL_W-1:0] ONE  = EL_W'(1);
   localparam logic [EL_W-1:0] SATV = '1;

   seq_st_e         st_q, st_d;
   logic [EL_W-1:0] seg_q, seg_d, el_q, el_d;
   logic [EL_W-1:0] seg_inc, el_inc, ts, tw;
   logic            rdy_gate;

   function automatic logic [EL_W-1:0] ext(logic [FLD_W-1:0] v);
      return EL_W'(v);
   endfunction

   assign seg_inc  = (seg_q == SATV) ? seg_q : seg_q + ONE;
   assign el_inc   = (el_q  == SATV) ? el_q  : el_q  + ONE;
   assign ts       = (tm.asu == '0) ? ONE : ext(tm.asu);
   assign tw       = is16 ? ((tm.w16 == '0) ? ONE : ext(tm.w16))
                          : ((tm.w8  == '0) ? ONE : ext(tm.w8));
   assign rdy_gate = !rdy_en || (seg_q < ext(tm.rdy)) || rdy;

   always_comb begin
      st_d     = st_q;
      seg_d    = seg_q;
      el_d     = el_q;
      load_en  = 1'b0;
      strb_end = 1'b0;
      fin      = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (start) begin
               seg_d = '0;
               el_d  = '0;
               st_d  = need_load ? ST_LOAD : ST_SETUP;
            end
         end
         ST_LOAD: begin
            load_en = 1'b1;
            st_d    = ST_SETUP;
         end
         ST_SETUP: begin
            el_d = el_inc;
            if (seg_inc >= ts) begin
               seg_d = '0;
               st_d  = ST_STRB;
            end else begin
               seg_d = seg_inc;
            end
         end
         ST_STRB: begin
            el_d = el_inc;
            if (seg_inc >= tw && rdy_gate) begin
               strb_end = 1'b1;
               seg_d    = '0;
               st_d     = (tm.hold == '0) ? ST_RECOV : ST_HOLD;
            end else begin
               seg_d = seg_inc;
            end
         end
         ST_HOLD: begin
            el_d = el_inc;
            if (seg_inc >= ext(tm.hold)) begin
               seg_d = '0;
               st_d  = ST_RECOV;
            end else begin
               seg_d = seg_inc;
            end
         end
         default: begin
            el_d = el_inc;
            if (el_inc >= ext(tm.cyc) && seg_inc >= ext(tm.rec)) begin
               fin  = 1'b1;
               st_d = ST_IDLE;
            end else begin
               seg_d = seg_inc;
            end
         end
      endcase
      if (soft_rst) begin
         st_d     = ST_IDLE;
         load_en  = 1'b0;
         strb_end = 1'b0;
         fin      = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         seg_q <= '0;
         el_q  <= '0;
      end else begin
         st_q  <= st_d;
         seg_q <= seg_d;
         el_q  <= el_d;
      end
   end

   assign st = st_q;

endmodule

// File: rtl/pio_xfer_eng.sv
`timescale 1ns/1ps
module pio_xfer_eng
   import pio_tm_pkg::*;
#(
   parameter int CLK_PS   = 5000,
   parameter int RDY_SYNC = 2,
   parameter int EL_W     = 10
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_sm_rst,
   input  logic        cfg_fifo_rst,
   input  logic        cfg_rdy_en,
   input  logic        tm_we,
   input  logic        tm_drive,
   input  logic        tm_word,
   input  logic [31:0] tm_wdata,
   input  logic        req_valid,
   output logic        req_ready,
   input  logic        req_drive,
   input  logic        req_cs,
   input  logic [2:0]  req_reg,
   input  logic        req_write,
   input  logic [15:0] req_wdata,
   output logic        done,
   output logic [15:0] rd_data,
   output logic        busy,
   output logic [1:0]  ata_cs_n,
   output logic [2:0]  ata_da,
   output logic        ata_dior_n,
   output logic        ata_diow_n,
   output logic [15:0] ata_dd_out,
   output logic        ata_dd_oe,
   input  logic [15:0] ata_dd_in,
   input  logic        ata_iordy
);

   // elaboration-time parameter checks
   if (CLK_PS < 1) begin : g_bad_period
      $error("pio_xfer_eng: CLK_PS must be positive");
   end
   if (CLK_PS > 0 && clk_cnt(600, (CLK_PS > 0) ? CLK_PS : 1) > 255) begin : g_bad_fit
      $error("pio_xfer_eng: clock too fast for 8-bit timing fields");
   end
   if (RDY_SYNC < 0 || RDY_SYNC > 3) begin : g_bad_sync
      $error("pio_xfer_eng: RDY_SYNC must be 0..3");
   end
   if (EL_W < 9) begin : g_bad_el
      $error("pio_xfer_eng: EL_W must be at least 9");
   end

   logic       soft_rst, accept, need_load, rdy_s;
   logic       load_en, strb_end, fin;
   seq_st_e    st;
   tm_set_t    bank_set, act_set_q;
   logic       act_drv_q, act_vld_q;
   logic       drv_q, cs_q, wr_q, is16_q;
   logic [2:0] reg_q;
   logic [15:0] wd_q, rd_q;
   logic       done_q, on_bus, strb_on;

   assign soft_rst  = cfg_sm_rst | cfg_fifo_rst;
   assign req_ready = (st == ST_IDLE) && !soft_rst;
   assign accept    = req_valid && req_ready;
   assign need_load = !act_vld_q || (req_drive != act_drv_q);

   pio_tm_bank #(.CLK_PS(CLK_PS)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (tm_we),
      .wr_drv  (tm_drive),
      .wr_word (tm_word),
      .wr_data (tm_wdata),
      .rd_drv  (drv_q),
      .rd_set  (bank_set)
   );

   pio_rdy_sync #(.STAGES(RDY_SYNC)) u_rdy (
      .clk     (clk),
      .rst_n   (rst_n),
      .rdy_in  (ata_iordy),
      .rdy_out (rdy_s)
   );

   pio_cycle_seq #(.EL_W(EL_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .soft_rst  (soft_rst),
      .start     (accept),
      .need_load (need_load),
      .is16      (is16_q),
      .rdy_en    (cfg_rdy_en),
      .rdy       (rdy_s),
      .tm        (act_set_q),
      .st        (st),
      .load_en   (load_en),
      .strb_end  (strb_end),
      .fin       (fin)
   );

   // request capture
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drv_q  <= 1'b0;
         cs_q   <= 1'b0;
         reg_q  <= '0;
         wr_q   <= 1'b0;
         wd_q   <= '0;
         is16_q <= 1'b0;
      end else if (accept) begin
         drv_q  <= req_drive;
         cs_q   <= req_cs;
         reg_q  <= req_reg;
         wr_q   <= req_write;
         wd_q   <= req_wdata;
         is16_q <= !req_cs && (req_reg == 3'd0);
      end
   end

   // working timing set
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_set_q <= '0;
         act_drv_q <= 1'b0;
         act_vld_q <= 1'b0;
      end else if (soft_rst) begin
         act_vld_q <= 1'b0;
      end else begin
         if (load_en) begin
            act_set_q <= bank_set;
            act_drv_q <= drv_q;
            act_vld_q <= 1'b1;
         end
         if (tm_we && tm_drive == (load_en ? drv_q : act_drv_q))
            act_vld_q <= 1'b0;
      end
   end

   // completion and read data
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         rd_q   <= '0;
      end else begin
         done_q <= fin;
         if (strb_end && !wr_q)
            rd_q <= is16_q ? ata_dd_in : {8'h00, ata_dd_in[7:0]};
      end
   end

   assign on_bus  = (st == ST_SETUP) || (st == ST_STRB) || (st == ST_HOLD);
   assign strb_on = (st == ST_STRB);

   assign busy       = (st != ST_IDLE);
   assign done       = done_q;
   assign rd_data    = rd_q;
   assign ata_cs_n   = on_bus ? (cs_q ? 2'b01 : 2'b10) : 2'b11;
   assign ata_da     = reg_q;
   assign ata_dior_n = !(strb_on && !wr_q);
   assign ata_diow_n = !(strb_on && wr_q);
   assign ata_dd_oe  = on_bus && wr_q;
   assign ata_dd_out = wd_q;

endmodule

// File: rtl/pio_xfer_chk.sv
`timescale 1ns/1ps
module pio_xfer_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        cfg_sm_rst,
   input logic        cfg_fifo_rst,
   input logic        req_ready,
   input logic        busy,
   input logic        done,
   input logic [1:0]  ata_cs_n,
   input logic        ata_dior_n,
   input logic        ata_diow_n,
   input logic        ata_dd_oe,
   input logic [15:0] ata_dd_out
);

   // R11
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ata_dior_n && !ata_diow_n));

   // R11
   read_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ata_dior_n |-> !ata_dd_oe);

   // R11
   wdata_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ata_diow_n && $past(!ata_diow_n)) |-> ($stable(ata_dd_out) && ata_dd_oe));

   // R3
   strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ata_dior_n || !ata_diow_n) |-> (ata_cs_n != 2'b11));

   // R8
   soft_rst_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_sm_rst || cfg_fifo_rst) |=> !busy);

   // R9
   ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !busy);

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

endmodule

bind pio_xfer_eng pio_xfer_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_sm_rst   (cfg_sm_rst),
   .cfg_fifo_rst (cfg_fifo_rst),
   .req_ready    (req_ready),
   .busy         (busy),
   .done         (done),
   .ata_cs_n     (ata_cs_n),
   .ata_dior_n   (ata_dior_n),
   .ata_diow_n   (ata_diow_n),
   .ata_dd_oe    (ata_dd_oe),
   .ata_dd_out   (ata_dd_out)
);

// File: tb/pio_xfer_eng_tb_top.sv
`timescale 1ns/1ps
module pio_xfer_eng_tb_top;

   localparam int CLK_PS = 5000;
   localparam int SYNC   = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_sm_rst = 1'b0, cfg_fifo_rst = 1'b0, cfg_rdy_en = 1'b0;
   logic        tm_we = 1'b0, tm_drive = 1'b0, tm_word = 1'b0;
   logic [31:0] tm_wdata = '0;
   logic        req_valid = 1'b0, req_drive = 1'b0, req_cs = 1'b0, req_write = 1'b0;
   logic [2:0]  req_reg = '0;
   logic [15:0] req_wdata = '0;
   logic [15:0] ata_dd_in = '0;
   logic        ata_iordy = 1'b1;
   logic        req_ready, done, busy, ata_dior_n, ata_diow_n, ata_dd_oe;
   logic [15:0] rd_data, ata_dd_out;
   logic [1:0]  ata_cs_n;
   logic [2:0]  ata_da;

   always #2.5 clk = ~clk;

   pio_xfer_eng #(.CLK_PS(CLK_PS), .RDY_SYNC(SYNC), .EL_W(10)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_sm_rst(cfg_sm_rst), .cfg_fifo_rst(cfg_fifo_rst),
      .cfg_rdy_en(cfg_rdy_en), .tm_we(tm_we), .tm_drive(tm_drive), .tm_word(tm_word),
      .tm_wdata(tm_wdata), .req_valid(req_valid), .req_ready(req_ready),
      .req_drive(req_drive), .req_cs(req_cs), .req_reg(req_reg), .req_write(req_write),
      .req_wdata(req_wdata), .done(done), .rd_data(rd_data), .busy(busy),
      .ata_cs_n(ata_cs_n), .ata_da(ata_da), .ata_dior_n(ata_dior_n),
      .ata_diow_n(ata_diow_n), .ata_dd_out(ata_dd_out), .ata_dd_oe(ata_dd_oe),
      .ata_dd_in(ata_dd_in), .ata_iordy(ata_iordy)
   );

   int n_chk = 0, n_err = 0;
   bit mdl_vld = 0;
   int mdl_drv = 0;
   int mode_of [2] = '{0, 0};

   int m_ld, m_su, m_st, m_hd, m_tot, m_exp_ld;
   logic [15:0] m_rd;
   bit m_bad, m_busy_done, m_done2;

   // expected nanosecond table, fields: 0 cycle,1 setup,2 w8,3 w16,4 rec,5 hold,6 ready
   function automatic int ns_tab(int f, int m);
      int t0 [5] = '{600, 383, 240, 180, 120};
      int ta [5] = '{70, 50, 30, 30, 25};
      int t8 [5] = '{290, 290, 290, 80, 70};
      int t16[5] = '{165, 125, 100, 80, 70};
      int tr [5] = '{0, 0, 0, 70, 25};
      int th [5] = '{30, 20, 15, 10, 10};
      case (f)
         0: return t0[m];
         1: return ta[m];
         2: return t8[m];
         3: return t16[m];
         4: return tr[m];
         5: return th[m];
         default: return 35;
      endcase
   endfunction

   function automatic int cc(int ns);
      return (ns * 1000 + CLK_PS - 1) / CLK_PS;
   endfunction

   function automatic int max2(int a, int b);
      return (a > b) ? a : b;
   endfunction

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic prog(int drv, int m);
      @(negedge clk);
      tm_we = 1'b1; tm_drive = drv[0]; tm_word = 1'b0;
      tm_wdata = {8'(cc(ns_tab(0, m))), 8'(cc(ns_tab(2, m))), 8'(cc(ns_tab(3, m))), 8'(cc(ns_tab(4, m)))};
      @(negedge clk);
      tm_word = 1'b1;
      tm_wdata = {8'(cc(ns_tab(5, m))), 8'(cc(ns_tab(1, m))), 8'(cc(ns_tab(6, m))), 8'h00};
      @(negedge clk);
      tm_we = 1'b0;
      mode_of[drv] = m;
      if (drv == mdl_drv) mdl_vld = 0;
   endtask

   task automatic xfer(int drv, bit csel, int rg, bit wr, logic [15:0] wd, logic [15:0] bus, int rel_at);
      bit seen_cs = 0;
      int guard = 0;
      logic [1:0] exp_cs = csel ? 2'b01 : 2'b10;
      m_ld = 0; m_su = 0; m_st = 0; m_hd = 0; m_tot = 0; m_bad = 0;
      m_exp_ld = (!mdl_vld || mdl_drv != drv) ? 1 : 0;
      mdl_vld = 1; mdl_drv = drv;
      @(negedge clk);
      req_valid = 1'b1; req_drive = drv[0]; req_cs = csel; req_reg = rg[2:0];
      req_write = wr; req_wdata = wd; ata_dd_in = bus;
      @(negedge clk);
      req_valid = 1'b0;
      while (done !== 1'b1 && guard < 2000) begin
         guard++;
         if (busy) begin
            if (ata_cs_n == 2'b11 && !seen_cs) m_ld++;
            else begin
               m_tot++;
               if (ata_cs_n != 2'b11) begin
                  seen_cs = 1;
                  if (ata_cs_n !== exp_cs || ata_da !== rg[2:0]) m_bad = 1;
                  if (wr && (ata_dd_oe !== 1'b1 || ata_dd_out !== wd)) m_bad = 1;
                  if (!wr && ata_dd_oe !== 1'b0) m_bad = 1;
                  if (!ata_dior_n || !ata_diow_n) begin
                     m_st++;
                     if (wr ? (ata_diow_n || !ata_dior_n) : (ata_dior_n || !ata_diow_n)) m_bad = 1;
                     if (rel_at > 0 && m_st == rel_at) ata_iordy = 1'b1;
                  end else if (m_st == 0) m_su++;
                  else m_hd++;
               end
            end
         end
         @(negedge clk);
      end
      m_rd = rd_data;
      m_busy_done = busy;
      @(negedge clk);
      m_done2 = done;
   endtask

   // runs one access and compares every phase against the requirement arithmetic
   task automatic run(int drv, bit csel, int rg, bit wr, logic [15:0] wd, logic [15:0] bus, int rel_at);
      int m, ts, tw, hd, s, n;
      bit is16;
      m = mode_of[drv];
      is16 = (csel == 1'b0 && rg == 0);
      xfer(drv, csel, rg, wr, wd, bus, rel_at);
      ts = max2(cc(ns_tab(1, m)), 1);
      tw = max2(cc(ns_tab(is16 ? 3 : 2, m)), 1);
      if (rel_at > 0) tw = rel_at + SYNC;
      hd = cc(ns_tab(5, m));
      s  = ts + tw + hd;
      n  = max2(cc(ns_tab(0, m)), s + max2(cc(ns_tab(4, m)), 1));
      chk("R5 set load cycles", m_ld, m_exp_ld);
      chk("R1 R3 setup cycles", m_su, ts);
      if (rel_at > 0) chk("R6 stretched strobe cycles", m_st, tw);
      else            chk("R1 R3 strobe cycles", m_st, tw);
      chk("R3 hold cycles", m_hd, hd);
      chk("R4 active cycles", m_tot, n);
      chk("R11 bus values during cycle", m_bad, 0);
      chk("R9 busy low with done", m_busy_done, 0);
      chk("R10 done one cycle", m_done2, 0);
      if (!wr) chk("R10 read data", m_rd, is16 ? bus : {8'h00, bus[7:0]});
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL R9 watchdog: run still active after 150000 cycles, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 idle state after reset
      chk("R2 reset cs_n", ata_cs_n, 3);
      chk("R2 reset dior_n", ata_dior_n, 1);
      chk("R2 reset diow_n", ata_diow_n, 1);
      chk("R2 reset dd_oe", ata_dd_oe, 0);
      chk("R2 reset busy", busy, 0);
      chk("R2 reset done", done, 0);
      chk("R9 ready at idle", req_ready, 1);

      // R2 default PIO0 set for both drives
      run(0, 0, 0, 0, 16'h0000, 16'hA55A, 0);
      chk("R2 default 16-bit strobe", m_st, cc(165));
      run(1, 0, 3, 1, 16'h00C3, 16'h0000, 0);
      chk("R2 default 8-bit strobe", m_st, cc(290));
      run(1, 1, 6, 0, 16'h0000, 16'h7E81, 0);

      // R1 R3 R4 R5 R10 R11 sweep over modes, drives and access kinds
      cfg_rdy_en = 1'b1;
      for (int m = 0; m < 5; m++) begin
         prog(0, m);
         prog(1, 4 - m);
         for (int d = 0; d < 2; d++) begin
            for (int k = 0; k < 4; k++) begin
               logic [15:0] pat;
               pat = 16'h1000 * (m + 1) + 16'h0100 * (d + 1) + 16'h0011 * (k + 1);
               case (k)
                  0: run(d, 0, 0, 0, 16'h0000, pat, 0);
                  1: run(d, 0, 0, 1, ~pat, 16'h0000, 0);
                  2: run(d, 0, 1 + k + m, 0, 16'h0000, pat, 0);
                  default: run(d, 1, 6, 1, pat, 16'h0000, 0);
               endcase
            end
         end
      end

      // R6 ready stretch: drive 0 now in mode 4
      ata_iordy = 1'b0;
      run(0, 0, 0, 0, 16'h0000, 16'hBEEF, cc(70) + 6);
      ata_iordy = 1'b1;
      // R7 ready ignored when disabled
      cfg_rdy_en = 1'b0;
      ata_iordy = 1'b0;
      run(0, 0, 0, 1, 16'h5AA5, 16'h0000, 0);
      chk("R7 width with ready low and disabled", m_st, cc(70));
      ata_iordy = 1'b1;
      cfg_rdy_en = 1'b1;

      // R8 soft reset bits abandon a cycle and refuse requests
      for (int b = 0; b < 2; b++) begin
         @(negedge clk);
         req_valid = 1'b1; req_drive = 1'b1; req_cs = 1'b0; req_reg = 3'd2;
         req_write = 1'b0;
         @(negedge clk);
         req_valid = 1'b0;
         repeat (20) @(negedge clk);
         chk("R8 strobe active before soft reset", ata_dior_n, 0);
         if (b == 0) cfg_sm_rst = 1'b1; else cfg_fifo_rst = 1'b1;
         @(negedge clk);
         chk("R8 busy after soft reset", busy, 0);
         chk("R8 strobe released", ata_dior_n, 1);
         chk("R8 cs released", ata_cs_n, 3);
         chk("R9 ready low in soft reset", req_ready, 0);
         req_valid = 1'b1; req_drive = 1'b0;
         repeat (3) begin
            @(negedge clk);
            chk("R8 request refused busy", busy, 0);
            chk("R8 no done in soft reset", done, 0);
         end
         req_valid = 1'b0;
         cfg_sm_rst = 1'b0; cfg_fifo_rst = 1'b0;
         mdl_vld = 0;
         run(1, 0, 0, 0, 16'h0000, 16'h3C3C + 16'(b), 0);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
   end

endmodule